// File: doc/BRIEF.md
# Real-Time Clock Timekeeping Core

This core keeps calendar time: seconds, minutes, hours, day of week, date, month and year. Each pulse on a one-per-second input advances the time by one second, with carries rippling through the calendar. Month lengths are applied, and February gets 29 days whenever the year value is a multiple of four. A small register port lets a host read and write the time fields, three alarm fields and four control and status registers. These sit at indices 0 to 13.

Control bits choose how the time fields are encoded, either BCD or plain binary. They also choose 24-hour mode or 12-hour mode; in 12-hour mode bit 7 of the hour byte marks PM. Further control bits enable three interrupt sources and can freeze time updates. The three sources are an alarm that fires when hours, minutes and seconds all match, a periodic tick divided from a 32.768 kHz reference pulse, and an update-ended event after each advance. A combined request bit and the `irq_o` output are raised when any enabled source has fired. Reading the flag register clears all of its flags.

Top module: `rtc_core`

## Requirements
- R1: Register indices are: 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 day of week, 7 date, 8 month, 9 year, 10 control A, 11 control B, 12 flags, 13 status. After reset, control A reads 26h, control B reads 02h (24-hour, BCD), flags read 00h, status reads 80h, day of week, date and month read 01h, and `irq_o` is low.
- R2: With control B bit 2 clear (BCD), a second tick advances the time in BCD. Seconds and minutes wrap from 59h to 00h. Hours wrap from 23h to 00h in 24-hour mode, and that carry moves the date on.
- R3: With control B bit 2 set (binary), the same fields count in binary. Seconds 09h becomes 0Ah, seconds and minutes wrap at 3Bh, hours at 17h, date 1Fh in month 0Ch rolls to 01h, and year 63h rolls to 00h.
- R4: With control B bit 1 clear (12-hour), hours run 1 to 12 and bit 7 set marks PM. 11 AM rolls to 12 PM (BCD 11h to 92h), 12 PM rolls to 1 PM (92h to 81h), and 11 PM rolls to 12 AM (91h to 12h) together with a date advance. The same rules hold in binary (8Bh to 0Ch).
- R5: The date wraps to 1 and the month advances after the last day of the month: 30 days for months 4, 6, 9 and 11, 31 for the other months except February, and for February 29 when the year is a multiple of four, otherwise 28. Month 12 wraps to 1 and advances the year, and year 99 wraps to 0.
- R6: Day of week advances from 1 to 7 on each day rollover and wraps from 7 back to 1.
- R7: Flag bit 5 (alarm) sets when an update leaves seconds, minutes and hours equal to the three alarm registers, and not when any one of them differs.
- R8: Control A bits 3:0 set the periodic rate: the flag bit 6 sets once every 2^(code-1) reference pulses. Code 0 disables it, codes 1 and 2 act as code 3, and a write to control A restarts the count.
- R9: A second tick raises control A bit 7 (update in progress) for exactly one cycle. The time fields then change, and flag bit 4 (update ended) sets.
- R10: While control B bit 7 is set, second ticks are ignored: the time does not change and the update-ended flag stays clear.
- R11: Control B bits 6, 5, 4 enable the periodic, alarm and update-ended flags respectively. Flag bit 7 and `irq_o` are high exactly when a flag is set together with its enable.
- R12: A read of the flag register with `reg_rd_i` high returns the flags and clears bits 7:4, which drops `irq_o`.
- R13: Seconds bit 7 and control A bit 7 are read-only. Writes to the flag and status registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_tick_i | input | 1 | One-cycle pulse, once per second |
| ref_tick_i | input | 1 | One-cycle pulse at the 32.768 kHz reference rate |
| reg_addr_i | input | 4 | Register index for reads and writes |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rd_i | input | 1 | Read strobe; clears the flags when the index is 12 |
| reg_rdata_o | output | 8 | Read data of the indexed register (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest states to reach from the ports are the rare carry chains. These are an 11 PM rollover in 12-hour mode, the end of February in leap and non-leap years, and the wrap at the end of a century. Waiting for them with real second ticks would take far too long. The bench instead loads each field directly to one second before the boundary, sends a single second tick, and reads every field that the carry should have touched. The periodic flag is checked one reference pulse before and exactly at its period, so an off-by-one in the divider shows up.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 4;

  typedef logic [REG_W-1:0] byte_t;

  localparam logic [ADDR_W-1:0] IX_SEC    = 4'd0;
  localparam logic [ADDR_W-1:0] IX_SEC_AL = 4'd1;
  localparam logic [ADDR_W-1:0] IX_MIN    = 4'd2;
  localparam logic [ADDR_W-1:0] IX_MIN_AL = 4'd3;
  localparam logic [ADDR_W-1:0] IX_HR     = 4'd4;
  localparam logic [ADDR_W-1:0] IX_HR_AL  = 4'd5;
  localparam logic [ADDR_W-1:0] IX_DOW    = 4'd6;
  localparam logic [ADDR_W-1:0] IX_DATE   = 4'd7;
  localparam logic [ADDR_W-1:0] IX_MON    = 4'd8;
  localparam logic [ADDR_W-1:0] IX_YEAR   = 4'd9;
  localparam logic [ADDR_W-1:0] IX_CTL_A  = 4'd10;
  localparam logic [ADDR_W-1:0] IX_CTL_B  = 4'd11;
  localparam logic [ADDR_W-1:0] IX_FLAGS  = 4'd12;
  localparam logic [ADDR_W-1:0] IX_STAT   = 4'd13;

  localparam byte_t CTL_A_RST = 8'h26;
  localparam byte_t CTL_B_RST = 8'h02;
  localparam byte_t STAT_VAL  = 8'h80;

  typedef struct packed {
    byte_t year;
    byte_t mon;
    byte_t date;
    byte_t dow;
    byte_t hr;
    byte_t min;
    byte_t sec;
  } tod_t;

  function automatic byte_t to_bin(byte_t v, logic bin);
    byte_t hi;
    hi = {4'h0, v[7:4]};
    return bin ? v : (hi * 8'd10 + {4'h0, v[3:0]});
  endfunction

  function automatic byte_t from_bin(byte_t v, logic bin);
    byte_t q, r;
    q = v / 8'd10;
    r = v % 8'd10;
    return bin ? v : {q[3:0], r[3:0]};
  endfunction

  // binary month and year
  function automatic byte_t month_len(byte_t mo, byte_t yr);
    case (mo)
      8'd2:                        return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:     return 8'd30;
      default:                     return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_calc.sv
module rtc_calc
  import rtc_pkg::*;
(
  input  tod_t cur_i,
  input  logic bin_mode_i,
  input  logic h24_mode_i,
  output tod_t nxt_o
);
  byte_t s, m, hraw, h24, dw, d, mo, y, h12, hdisp, hb;
  logic  c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    s    = to_bin(cur_i.sec, bin_mode_i);
    m    = to_bin(cur_i.min, bin_mode_i);
    hraw = to_bin({1'b0, cur_i.hr[6:0]}, bin_mode_i);
    dw   = cur_i.dow;
    d    = to_bin(cur_i.date, bin_mode_i);
    mo   = to_bin(cur_i.mon, bin_mode_i);
    y    = to_bin(cur_i.year, bin_mode_i);

    // normalise hour to 0..23
    if (h24_mode_i) h24 = hraw;
    else            h24 = (hraw % 8'd12) + (cur_i.hr[7] ? 8'd12 : 8'd0);

    c_min = (s >= 8'd59);
    s     = c_min ? 8'd0 : s + 8'd1;
    c_hr  = c_min && (m >= 8'd59);
    if (c_min) m = c_hr ? 8'd0 : m + 8'd1;
    c_day = c_hr && (h24 >= 8'd23);
    if (c_hr) h24 = c_day ? 8'd0 : h24 + 8'd1;
    if (c_day) dw = (dw >= 8'd7) ? 8'd1 : dw + 8'd1;
    c_mon = c_day && (d >= month_len(mo, y));
    if (c_day) d = c_mon ? 8'd1 : d + 8'd1;
    c_yr  = c_mon && (mo >= 8'd12);
    if (c_mon) mo = c_yr ? 8'd1 : mo + 8'd1;
    if (c_yr) y = (y >= 8'd99) ? 8'd0 : y + 8'd1;

    h12   = h24 % 8'd12;
    hdisp = (h12 == 8'd0) ? 8'd12 : h12;
    hb    = from_bin(hdisp, bin_mode_i);

    nxt_o.sec  = from_bin(s, bin_mode_i);
    nxt_o.min  = from_bin(m, bin_mode_i);
    nxt_o.hr   = h24_mode_i ? from_bin(h24, bin_mode_i)
                            : {(h24 >= 8'd12), hb[6:0]};
    nxt_o.dow  = dw;
    nxt_o.date = from_bin(d, bin_mode_i);
    nxt_o.mon  = from_bin(mo, bin_mode_i);
    nxt_o.year = from_bin(y, bin_mode_i);
  end
endmodule

// File: rtl/rtc_rate_div.sv
module rtc_rate_div #(
  parameter int unsigned CNT_W  = 15,
  parameter int unsigned RATE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              restart_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              hit_o
);
  localparam logic [RATE_W-1:0] MIN_CODE = RATE_W'(3);
  localparam logic [CNT_W-1:0]  ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [RATE_W-1:0] eff;
  logic [CNT_W-1:0]  cnt_q, last_v;
  logic              off;

  always_comb begin
    off    = (rate_i == '0);
    eff    = (!off && rate_i < MIN_CODE) ? MIN_CODE : rate_i;
    last_v = (ONE << (eff - 1'b1)) - ONE;
  end

  assign hit_o = ref_tick_i && !off && (cnt_q >= last_v);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i || off)  cnt_q <= '0;
    else if (ref_tick_i)        cnt_q <= hit_o ? '0 : cnt_q + ONE;
  end

  a_r8_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_tick_i && !hit_o && !restart_i && !off) |=> (cnt_q == $past(cnt_q) + ONE));

  a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_tick_i && !restart_i && !off) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned REF_CNT_W = 15,
  parameter int unsigned RATE_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sec_tick_i,
  input  logic                ref_tick_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_wr_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  input  logic                reg_rd_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  output logic                irq_o
);
  tod_t       tod_q, tod_nxt;
  byte_t      al_sec_q, al_min_q, al_hr_q, ctl_b_q;
  logic [6:0] ctl_a_q;
  logic       uip_q, pf_q, af_q, uf_q;
  logic       inhibit, start, commit, rd_flags, restart, pf_hit, al_hit, irq;

  assign inhibit  = ctl_b_q[7];
  assign start    = sec_tick_i && !inhibit && !uip_q;
  assign commit   = uip_q;
  assign rd_flags = reg_rd_i && (reg_addr_i == IX_FLAGS);
  assign restart  = reg_wr_i && (reg_addr_i == IX_CTL_A);

  rtc_calc u_calc (
    .cur_i      (tod_q),
    .bin_mode_i (ctl_b_q[2]),
    .h24_mode_i (ctl_b_q[1]),
    .nxt_o      (tod_nxt)
  );

  rtc_rate_div #(.CNT_W(REF_CNT_W), .RATE_W(RATE_W)) u_rate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_tick_i (ref_tick_i),
    .restart_i  (restart),
    .rate_i     (ctl_a_q[RATE_W-1:0]),
    .hit_o      (pf_hit)
  );

  assign al_hit = commit && (tod_nxt.sec == al_sec_q) &&
                  (tod_nxt.min == al_min_q) && (tod_nxt.hr == al_hr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tod_q    <= '{year: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h01,
                    hr: 8'h00, min: 8'h00, sec: 8'h00};
      al_sec_q <= '0;
      al_min_q <= '0;
      al_hr_q  <= '0;
      ctl_a_q  <= CTL_A_RST[6:0];
      ctl_b_q  <= CTL_B_RST;
      uip_q    <= 1'b0;
    end else begin
      uip_q <= start;
      if (commit) tod_q <= tod_nxt;
      // host write wins over a same-cycle advance
      if (reg_wr_i) begin
        case (reg_addr_i)
          IX_SEC:    tod_q.sec  <= {1'b0, reg_wdata_i[6:0]};
          IX_SEC_AL: al_sec_q   <= reg_wdata_i;
          IX_MIN:    tod_q.min  <= reg_wdata_i;
          IX_MIN_AL: al_min_q   <= reg_wdata_i;
          IX_HR:     tod_q.hr   <= reg_wdata_i;
          IX_HR_AL:  al_hr_q    <= reg_wdata_i;
          IX_DOW:    tod_q.dow  <= reg_wdata_i;
          IX_DATE:   tod_q.date <= reg_wdata_i;
          IX_MON:    tod_q.mon  <= reg_wdata_i;
          IX_YEAR:   tod_q.year <= reg_wdata_i;
          IX_CTL_A:  ctl_a_q    <= reg_wdata_i[6:0];
          IX_CTL_B:  ctl_b_q    <= reg_wdata_i;
          default:   ;
        endcase
      end
    end
  end

  // new events win over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_q <= 1'b0;
      af_q <= 1'b0;
      uf_q <= 1'b0;
    end else begin
      pf_q <= pf_hit | (pf_q & ~rd_flags);
      af_q <= al_hit | (af_q & ~rd_flags);
      uf_q <= commit | (uf_q & ~rd_flags);
    end
  end

  assign irq   = (pf_q & ctl_b_q[6]) | (af_q & ctl_b_q[5]) | (uf_q & ctl_b_q[4]);
  assign irq_o = irq;

  always_comb begin
    case (reg_addr_i)
      IX_SEC:    reg_rdata_o = tod_q.sec;
      IX_SEC_AL: reg_rdata_o = al_sec_q;
      IX_MIN:    reg_rdata_o = tod_q.min;
      IX_MIN_AL: reg_rdata_o = al_min_q;
      IX_HR:     reg_rdata_o = tod_q.hr;
      IX_HR_AL:  reg_rdata_o = al_hr_q;
      IX_DOW:    reg_rdata_o = tod_q.dow;
      IX_DATE:   reg_rdata_o = tod_q.date;
      IX_MON:    reg_rdata_o = tod_q.mon;
      IX_YEAR:   reg_rdata_o = tod_q.year;
      IX_CTL_A:  reg_rdata_o = {uip_q, ctl_a_q};
      IX_CTL_B:  reg_rdata_o = ctl_b_q;
      IX_FLAGS:  reg_rdata_o = {irq, pf_q, af_q, uf_q, 4'h0};
      IX_STAT:   reg_rdata_o = STAT_VAL;
      default:   reg_rdata_o = '0;
    endcase
  end

  a_r9_uip_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uip_q |=> !uip_q);

  a_r10_inhibit_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit |=> !uip_q);

  a_r12_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_flags && !pf_hit && !commit) |=> !irq_o);

  a_r2_time_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uip_q && !reg_wr_i) |=> $stable(tod_q));

  a_r7_alarm_on_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(af_q) |-> $past(uip_q));

  a_r11_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctl_b_q[6:4] != 3'b000));
endmodule

// File: tb/rtc_core_tb_top.sv
module rtc_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       ref_tick = 1'b0;
  logic [3:0] addr = 4'd0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       rd = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_core dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sec_tick_i  (sec_tick),
    .ref_tick_i  (ref_tick),
    .reg_addr_i  (addr),
    .reg_wr_i    (wr),
    .reg_wdata_i (wdata),
    .reg_rd_i    (rd),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic chk_irq(input string req, input logic exp);
    #1 chk(req, {7'h0, irq}, {7'h0, exp});
  endtask

  task automatic clr_flags(output logic [7:0] v);
    @(negedge clk); addr = 4'd12; rd = 1'b1; #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic ref_pulses(input int n);
    @(negedge clk); ref_tick = 1'b1;
    repeat (n) @(negedge clk);
    ref_tick = 1'b0;
  endtask

  task automatic set_tod(input logic [7:0] yr, mo, dt, dw, hr, mi, se);
    wr_reg(4'd9, yr); wr_reg(4'd8, mo); wr_reg(4'd7, dt); wr_reg(4'd6, dw);
    wr_reg(4'd4, hr); wr_reg(4'd2, mi); wr_reg(4'd0, se);
  endtask

  task automatic t_reset();
    chk_reg("R1 ctl A reset", 4'd10, 8'h26);
    chk_reg("R1 ctl B reset", 4'd11, 8'h02);
    chk_reg("R1 flags reset", 4'd12, 8'h00);
    chk_reg("R1 status", 4'd13, 8'h80);
    chk_reg("R1 dow reset", 4'd6, 8'h01);
    chk_reg("R1 date reset", 4'd7, 8'h01);
    chk_reg("R1 month reset", 4'd8, 8'h01);
    chk_irq("R1 irq reset", 1'b0);
  endtask

  task automatic t_bcd();
    logic [7:0] v;
    wr_reg(4'd11, 8'h02);
    set_tod(8'h05, 8'h03, 8'h10, 8'h02, 8'h12, 8'h30, 8'h09);
    tick();
    chk_reg("R2 bcd 09->10", 4'd0, 8'h10);
    set_tod(8'h05, 8'h03, 8'h10, 8'h02, 8'h23, 8'h59, 8'h59);
    tick();
    chk_reg("R2 sec wrap", 4'd0, 8'h00);
    chk_reg("R2 min wrap", 4'd2, 8'h00);
    chk_reg("R2 hour wrap", 4'd4, 8'h00);
    chk_reg("R2 date carry", 4'd7, 8'h11);
    clr_flags(v);
  endtask

  task automatic t_binary();
    logic [7:0] v;
    wr_reg(4'd11, 8'h06);
    set_tod(8'h05, 8'h03, 8'h10, 8'h02, 8'h05, 8'h05, 8'h09);
    tick();
    chk_reg("R3 bin 09->0A", 4'd0, 8'h0A);
    set_tod(8'h63, 8'h0C, 8'h1F, 8'h07, 8'h17, 8'h3B, 8'h3B);
    tick();
    chk_reg("R3 bin hour wrap", 4'd4, 8'h00);
    chk_reg("R3 bin min wrap", 4'd2, 8'h00);
    chk_reg("R3 bin date wrap", 4'd7, 8'h01);
    chk_reg("R3 bin month wrap", 4'd8, 8'h01);
    chk_reg("R3 bin year wrap", 4'd9, 8'h00);
    chk_reg("R6 dow 7->1 binary", 4'd6, 8'h01);
    clr_flags(v);
  endtask

  task automatic t_12h();
    logic [7:0] v;
    wr_reg(4'd11, 8'h00);
    set_tod(8'h05, 8'h03, 8'h05, 8'h03, 8'h11, 8'h59, 8'h59);
    tick();
    chk_reg("R4 11AM->12PM", 4'd4, 8'h92);
    set_tod(8'h05, 8'h03, 8'h05, 8'h03, 8'h92, 8'h59, 8'h59);
    tick();
    chk_reg("R4 12PM->1PM", 4'd4, 8'h81);
    set_tod(8'h05, 8'h03, 8'h05, 8'h03, 8'h91, 8'h59, 8'h59);
    tick();
    chk_reg("R4 11PM->12AM", 4'd4, 8'h12);
    chk_reg("R4 date advance", 4'd7, 8'h06);
    chk_reg("R6 dow 3->4", 4'd6, 8'h04);
    wr_reg(4'd11, 8'h04);
    set_tod(8'h05, 8'h03, 8'h05, 8'h03, 8'h8B, 8'h3B, 8'h3B);
    tick();
    chk_reg("R4 binary 11PM->12AM", 4'd4, 8'h0C);
    clr_flags(v);
  endtask

  task automatic t_month_end();
    logic [7:0] v;
    wr_reg(4'd11, 8'h02);
    set_tod(8'h24, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59);
    tick();
    chk_reg("R5 leap feb 29", 4'd7, 8'h29);
    chk_reg("R5 leap month held", 4'd8, 8'h02);
    chk_reg("R6 dow 7->1", 4'd6, 8'h01);
    set_tod(8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    tick();
    chk_reg("R5 nonleap date", 4'd7, 8'h01);
    chk_reg("R5 nonleap month", 4'd8, 8'h03);
    set_tod(8'h23, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    tick();
    chk_reg("R5 30-day month", 4'd8, 8'h05);
    set_tod(8'h99, 8'h12, 8'h31, 8'h01, 8'h23, 8'h59, 8'h59);
    tick();
    chk_reg("R5 dec31 date", 4'd7, 8'h01);
    chk_reg("R5 dec31 month", 4'd8, 8'h01);
    chk_reg("R5 year 99->00", 4'd9, 8'h00);
    clr_flags(v);
  endtask

  task automatic t_uip();
    logic [7:0] v;
    wr_reg(4'd11, 8'h02);
    wr_reg(4'd0, 8'h20);
    clr_flags(v);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0; addr = 4'd10; #1;
    chk("R9 uip high", rdata, 8'hA6);
    @(negedge clk); #1;
    chk("R9 uip low", rdata, 8'h26);
    chk_reg("R9 time advanced", 4'd0, 8'h21);
    chk_reg("R9 update flag", 4'd12, 8'h10);
    clr_flags(v);
  endtask

  task automatic t_inhibit();
    logic [7:0] v;
    wr_reg(4'd11, 8'h92);
    wr_reg(4'd0, 8'h10);
    clr_flags(v);
    tick();
    chk_reg("R10 time frozen", 4'd0, 8'h10);
    chk_reg("R10 no update flag", 4'd12, 8'h00);
    chk_irq("R10 no irq", 1'b0);
    wr_reg(4'd11, 8'h02);
  endtask

  task automatic t_alarm();
    logic [7:0] v;
    wr_reg(4'd11, 8'h22);
    wr_reg(4'd1, 8'h30); wr_reg(4'd3, 8'h20); wr_reg(4'd5, 8'h10);
    set_tod(8'h05, 8'h03, 8'h10, 8'h02, 8'h10, 8'h20, 8'h29);
    clr_flags(v);
    tick();
    chk_reg("R7 alarm match", 4'd12, 8'hB0);
    chk_irq("R11 alarm irq", 1'b1);
    clr_flags(v);
    chk("R12 read returns flags", v, 8'hB0);
    chk_irq("R12 irq dropped", 1'b0);
    chk_reg("R12 flags cleared", 4'd12, 8'h00);
    set_tod(8'h05, 8'h03, 8'h10, 8'h02, 8'h10, 8'h21, 8'h29);
    tick();
    chk_reg("R7 minute differs", 4'd12, 8'h10);
    chk_irq("R11 update not enabled", 1'b0);
    clr_flags(v);
    wr_reg(4'd11, 8'h12);
    tick();
    chk_reg("R11 update enabled", 4'd12, 8'h90);
    chk_irq("R11 update irq", 1'b1);
    clr_flags(v);
    wr_reg(4'd11, 8'h02);
  endtask

  task automatic t_periodic();
    logic [7:0] v;
    wr_reg(4'd11, 8'h42);
    wr_reg(4'd10, 8'h23);
    clr_flags(v);
    ref_pulses(3);
    chk_reg("R8 code3 before period", 4'd12, 8'h00);
    ref_pulses(1);
    chk_reg("R8 code3 at 4 pulses", 4'd12, 8'hC0);
    chk_irq("R11 periodic irq", 1'b1);
    clr_flags(v);
    wr_reg(4'd10, 8'h20);
    ref_pulses(40);
    chk_reg("R8 code0 off", 4'd12, 8'h00);
    wr_reg(4'd11, 8'h02);
    wr_reg(4'd10, 8'h21);
    ref_pulses(3);
    chk_reg("R8 code1 before period", 4'd12, 8'h00);
    ref_pulses(1);
    chk_reg("R8 code1 acts as 3", 4'd12, 8'h40);
    chk_irq("R11 periodic not enabled", 1'b0);
    clr_flags(v);
    wr_reg(4'd10, 8'h25);
    ref_pulses(15);
    chk_reg("R8 code5 before period", 4'd12, 8'h00);
    ref_pulses(1);
    chk_reg("R8 code5 at 16 pulses", 4'd12, 8'h40);
    clr_flags(v);
    wr_reg(4'd10, 8'h26);
  endtask

  task automatic t_readonly();
    logic [7:0] v;
    wr_reg(4'd0, 8'hD5);
    chk_reg("R13 sec bit7 ro", 4'd0, 8'h55);
    clr_flags(v);
    wr_reg(4'd12, 8'hF0);
    chk_reg("R13 flags write ignored", 4'd12, 8'h00);
    wr_reg(4'd13, 8'h00);
    chk_reg("R13 status write ignored", 4'd13, 8'h80);
    wr_reg(4'd10, 8'hFF);
    chk_reg("R13 ctl A bit7 ro", 4'd10, 8'h7F);
    wr_reg(4'd10, 8'h26);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bcd();
    t_binary();
    t_12h();
    t_month_end();
    t_uip();
    t_inhibit();
    t_alarm();
    t_periodic();
    t_readonly();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule